// File: doc/BRIEF.md
# Coprocessor Access Permission Checker

This block decides, for every coprocessor instruction that reaches it, whether the instruction may go ahead or must raise an undefined-instruction trap. It holds a 32-bit permission register that gives each coprocessor a two-bit access field. It also holds a separate enable register with one bit per coprocessor, used when a configuration input selects the simpler one-bit scheme. The coprocessor number is taken from the instruction word. Coprocessor numbers 14 and 15 are never restricted here.

Software writes and reads both registers through a small register port. Writes to the permission register pass through a mask that depends on whether the floating-point coprocessor is built in. Bits of coprocessors that do not exist always read as zero. The decision is combinational from the instruction, the privilege input and the current register contents. It is qualified by an instruction-valid strobe. A reserved field encoding causes a trap, and it also raises a flag for the same cycle.

Top module: `cp_access_gate`

## Requirements
- R1: After reset both registers read zero, and every valid instruction to coprocessors 0 to 13 traps in either privilege level.
- R2: The coprocessor number is insn_word[11:8]. Numbers 14 and 15 are always allowed and never raise rsvd_pulse, under both schemes and at both privilege levels.
- R3: In the field scheme (cfg_bit_scheme=0), coprocessor n uses permission bits [2n+1:2n]. The value 00 traps at both privilege levels (priv_mode=1 is privileged, 0 is user).
- R4: Field value 01 allows privileged access and traps user access.
- R5: Field value 11 allows access at both privilege levels.
- R6: Field value 10 traps at both privilege levels and asserts rsvd_pulse in the same cycle as the valid strobe.
- R7: With cfg_fp_present=1, a write to the permission register (reg_sel=0) keeps only bits [23:20], the fields of coprocessors 10 and 11. Readback shows the masked value.
- R8: With cfg_fp_present=0, a permission register write stores zero, so the register reads zero and coprocessors 10 and 11 trap.
- R9: In the one-bit scheme (cfg_bit_scheme=1), coprocessor n below 14 traps when enable bit n is clear and is allowed when it is set, at either privilege level. rsvd_pulse stays low.
- R10: While insn_valid is low, allow, trap and rsvd_pulse are all low.
- R11: A register write changes the decision from the cycle after the write edge. In the cycle of the write, the old contents decide.
- R12: The enable register (reg_sel=1) stores write bits [13:0]. Its readback bits [31:14] are always zero.
- R13: When insn_valid is high, exactly one of allow and trap is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fp_present | input | 1 | Floating-point coprocessor built in; selects the write mask |
| cfg_bit_scheme | input | 1 | 1 selects the one-bit enable scheme, 0 the two-bit field scheme |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 permission register, 1 enable register |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Readback of the selected register |
| insn_valid | input | 1 | Instruction present this cycle |
| insn_word | input | 32 | Coprocessor instruction word |
| priv_mode | input | 1 | 1 privileged, 0 user |
| allow | output | 1 | Instruction may proceed |
| trap | output | 1 | Instruction must raise an undefined-instruction trap |
| rsvd_pulse | output | 1 | Reserved field encoding seen on this instruction |

## Verification
A corrupted permission field appears at once as a wrong allow or trap on the next valid instruction to that coprocessor. It appears as a missing or spurious rsvd_pulse if the corrupted field reads 10. A lost or misplaced write mask shows on the very next readback as bits outside [23:20]. It also shows as permission granted to a coprocessor that should always trap. A write that lands a cycle late or early is seen only by sampling the decision in the write cycle and in the cycle after, so the bench probes both cycles.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
    localparam int CPG_DATA_W  = 32;
    localparam int CPG_NUM_CP  = 14;
    localparam int CPG_CP_W    = 4;
    localparam int CPG_CP_LSB  = 8;

    typedef enum logic {
        SEL_PERM   = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [CPG_DATA_W-1:0] perm;
        logic [CPG_NUM_CP-1:0] enable;
    } cpg_state_t;
endpackage

// File: rtl/cpg_regs.sv
module cpg_regs
    import cpg_pkg::*;
#(
    parameter logic [CPG_DATA_W-1:0] FP_MASK = 32'h00F0_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fp_present,
    input  logic                  wr_en,
    input  logic                  sel,
    input  logic [CPG_DATA_W-1:0] wr_data,
    output logic [CPG_DATA_W-1:0] perm_q,
    output logic [CPG_NUM_CP-1:0] enable_q,
    output logic [CPG_DATA_W-1:0] rd_data
);
    cpg_state_t state_d, state_q;
    logic [CPG_DATA_W-1:0] wmask;

    always_comb begin
        wmask   = fp_present ? FP_MASK : '0;
        state_d = state_q;
        if (wr_en) begin
            if (reg_sel_e'(sel) == SEL_PERM) begin
                state_d.perm = wr_data & wmask;
            end else begin
                state_d.enable = wr_data[CPG_NUM_CP-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign perm_q   = state_q.perm;
    assign enable_q = state_q.enable;

    always_comb begin
        if (reg_sel_e'(sel) == SEL_PERM) begin
            rd_data = state_q.perm;
        end else begin
            rd_data = {{(CPG_DATA_W-CPG_NUM_CP){1'b0}}, state_q.enable};
        end
    end
endmodule

// File: rtl/cpg_decide.sv
module cpg_decide
    import cpg_pkg::*;
(
    input  logic [CPG_CP_W-1:0]   cp_num,
    input  logic                  priv,
    input  logic                  bit_scheme,
    input  logic [CPG_DATA_W-1:0] perm_q,
    input  logic [CPG_NUM_CP-1:0] enable_q,
    output logic                  pass,
    output logic                  rsvd
);
    logic [CPG_NUM_CP-1:0] fld_pass;
    logic [CPG_NUM_CP-1:0] fld_rsvd;

    for (genvar g = 0; g < CPG_NUM_CP; g++) begin : g_field
        logic [1:0] fld;
        assign fld         = perm_q[2*g +: 2];
        assign fld_pass[g] = (fld == 2'b11) || ((fld == 2'b01) && priv);
        assign fld_rsvd[g] = (fld == 2'b10);
    end

    if (2*CPG_NUM_CP < CPG_DATA_W) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^perm_q[CPG_DATA_W-1:2*CPG_NUM_CP];
    end

    logic checked;
    assign checked = (int'(cp_num) < CPG_NUM_CP);

    always_comb begin
        pass = 1'b1;
        rsvd = 1'b0;
        if (checked) begin
            if (bit_scheme) begin
                pass = enable_q[cp_num];
            end else begin
                pass = fld_pass[cp_num];
                rsvd = fld_rsvd[cp_num];
            end
        end
    end
endmodule

// File: rtl/cp_access_gate.sv
module cp_access_gate
    import cpg_pkg::*;
#(
    parameter logic [CPG_DATA_W-1:0] FP_MASK = 32'h00F0_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_fp_present,
    input  logic                  cfg_bit_scheme,
    input  logic                  reg_wr_en,
    input  logic                  reg_sel,
    input  logic [CPG_DATA_W-1:0] reg_wr_data,
    output logic [CPG_DATA_W-1:0] reg_rd_data,
    input  logic                  insn_valid,
    input  logic [CPG_DATA_W-1:0] insn_word,
    input  logic                  priv_mode,
    output logic                  allow,
    output logic                  trap,
    output logic                  rsvd_pulse
);
    logic [CPG_DATA_W-1:0] perm_q;
    logic [CPG_NUM_CP-1:0] enable_q;
    logic [CPG_CP_W-1:0]   cp_num;
    logic                  pass, rsvd;
    logic                  unused_insn;

    assign cp_num      = insn_word[CPG_CP_LSB +: CPG_CP_W];
    assign unused_insn = ^{insn_word[CPG_DATA_W-1:CPG_CP_LSB+CPG_CP_W],
                           insn_word[CPG_CP_LSB-1:0]};

    cpg_regs #(.FP_MASK(FP_MASK)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_present (cfg_fp_present),
        .wr_en      (reg_wr_en),
        .sel        (reg_sel),
        .wr_data    (reg_wr_data),
        .perm_q     (perm_q),
        .enable_q   (enable_q),
        .rd_data    (reg_rd_data)
    );

    cpg_decide u_decide (
        .cp_num     (cp_num),
        .priv       (priv_mode),
        .bit_scheme (cfg_bit_scheme),
        .perm_q     (perm_q),
        .enable_q   (enable_q),
        .pass       (pass),
        .rsvd       (rsvd)
    );

    assign allow      = insn_valid &&  pass;
    assign trap       = insn_valid && !pass;
    assign rsvd_pulse = insn_valid &&  rsvd;
endmodule

// File: rtl/cpg_checker.sv
module cpg_checker
    import cpg_pkg::*;
#(
    parameter logic [CPG_DATA_W-1:0] FP_MASK = 32'h00F0_0000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_fp_present,
    input logic                  cfg_bit_scheme,
    input logic                  reg_wr_en,
    input logic                  reg_sel,
    input logic [CPG_DATA_W-1:0] reg_wr_data,
    input logic [CPG_DATA_W-1:0] reg_rd_data,
    input logic                  insn_valid,
    input logic [CPG_DATA_W-1:0] insn_word,
    input logic                  allow,
    input logic                  trap,
    input logic                  rsvd_pulse,
    input logic [CPG_DATA_W-1:0] perm_q
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |-> (!allow && !trap && !rsvd_pulse)); // R10

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> (allow != trap)); // R13

    AST_HIGH_CP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[11:8] >= 4'd14) |-> (allow && !rsvd_pulse)); // R2

    AST_RSVD_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_pulse |-> trap); // R6

    AST_BIT_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bit_scheme |-> !rsvd_pulse); // R9

    AST_PERM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> ((reg_rd_data & ~FP_MASK) == '0)); // R7

    AST_ENABLE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rd_data[CPG_DATA_W-1:CPG_NUM_CP] == '0)); // R12

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_sel) |=>
            (perm_q == ($past(reg_wr_data) & ($past(cfg_fp_present) ? FP_MASK : '0)))); // R11
endmodule

bind cp_access_gate cpg_checker #(.FP_MASK(FP_MASK)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_fp_present (cfg_fp_present),
    .cfg_bit_scheme (cfg_bit_scheme),
    .reg_wr_en      (reg_wr_en),
    .reg_sel        (reg_sel),
    .reg_wr_data    (reg_wr_data),
    .reg_rd_data    (reg_rd_data),
    .insn_valid     (insn_valid),
    .insn_word      (insn_word),
    .allow          (allow),
    .trap           (trap),
    .rsvd_pulse     (rsvd_pulse),
    .perm_q         (perm_q)
);

// File: tb/cp_access_gate_test.sv
module cp_access_gate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fp_present = 1'b1;
    logic        cfg_bit_scheme = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        priv_mode = 1'b0;
    logic        allow, trap, rsvd_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    cp_access_gate uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_fp_present (cfg_fp_present),
        .cfg_bit_scheme (cfg_bit_scheme),
        .reg_wr_en      (reg_wr_en),
        .reg_sel        (reg_sel),
        .reg_wr_data    (reg_wr_data),
        .reg_rd_data    (reg_rd_data),
        .insn_valid     (insn_valid),
        .insn_word      (insn_word),
        .priv_mode      (priv_mode),
        .allow          (allow),
        .trap           (trap),
        .rsvd_pulse     (rsvd_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wr_data = data; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_expect(input logic sel, input logic [31:0] exp, input string req);
        reg_sel = sel;
        #1;
        check(reg_rd_data == exp, req, "readback", reg_rd_data, exp);
    endtask

    // expected decision: a = allow, t = trap, r = rsvd_pulse
    task automatic probe(input logic [3:0] cp, input logic priv, input logic [31:0] noise,
                         input bit a, input bit t, input bit r, input string req);
        insn_word  = (noise & 32'hFFFF_F0FF) | {20'd0, cp, 8'd0};
        priv_mode  = priv;
        insn_valid = 1'b1;
        #1;
        check(allow == a, req, $sformatf("allow cp%0d priv%0d", cp, priv), {31'd0, allow}, {31'd0, a});
        check(trap == t, req, $sformatf("trap cp%0d priv%0d", cp, priv), {31'd0, trap}, {31'd0, t});
        check(rsvd_pulse == r, req, $sformatf("rsvd cp%0d priv%0d", cp, priv), {31'd0, rsvd_pulse}, {31'd0, r});
        insn_valid = 1'b0;
    endtask

    task automatic t_reset;
        read_expect(1'b0, 32'h0, "R1");
        read_expect(1'b1, 32'h0, "R1");
        probe(4'd0, 1'b1, 32'h0, 0, 1, 0, "R1");
        probe(4'd10, 1'b1, 32'h0, 0, 1, 0, "R1");
        probe(4'd13, 1'b0, 32'h0, 0, 1, 0, "R1");
    endtask

    task automatic t_high_cp;
        cfg_bit_scheme = 1'b0;
        probe(4'd14, 1'b0, 32'hDEAD_BEEF, 1, 0, 0, "R2");
        probe(4'd15, 1'b1, 32'h1234_5678, 1, 0, 0, "R2");
        cfg_bit_scheme = 1'b1;
        probe(4'd15, 1'b0, 32'hFFFF_FFFF, 1, 0, 0, "R2");
        cfg_bit_scheme = 1'b0;
    endtask

    task automatic t_mask;
        cfg_fp_present = 1'b1;
        write_reg(1'b0, 32'hFFFF_FFFF);
        read_expect(1'b0, 32'h00F0_0000, "R7");
        probe(4'd0, 1'b1, 32'h0, 0, 1, 0, "R7");
        probe(4'd11, 1'b0, 32'h0, 1, 0, 0, "R7");
        cfg_fp_present = 1'b0;
        write_reg(1'b0, 32'hFFFF_FFFF);
        read_expect(1'b0, 32'h0, "R8");
        probe(4'd10, 1'b1, 32'h0, 0, 1, 0, "R8");
        cfg_fp_present = 1'b1;
    endtask

    task automatic t_fields;
        // cp11 field = 11, cp10 field = 01
        write_reg(1'b0, 32'h00D0_0000);
        probe(4'd10, 1'b1, 32'h0EE0_0011, 1, 0, 0, "R4");
        probe(4'd10, 1'b0, 32'h0EE0_0011, 0, 1, 0, "R4");
        probe(4'd11, 1'b1, 32'h0, 1, 0, 0, "R5");
        probe(4'd11, 1'b0, 32'h0, 1, 0, 0, "R5");
        // cp10 field = 10, cp11 field = 00
        write_reg(1'b0, 32'h0020_0000);
        probe(4'd10, 1'b1, 32'h0, 0, 1, 1, "R6");
        probe(4'd10, 1'b0, 32'h0, 0, 1, 1, "R6");
        probe(4'd11, 1'b1, 32'h0, 0, 1, 0, "R3");
        probe(4'd11, 1'b0, 32'h0, 0, 1, 0, "R3");
    endtask

    task automatic t_gate;
        insn_word  = 32'h0000_0A00;
        priv_mode  = 1'b1;
        insn_valid = 1'b0;
        #1;
        check(!allow && !trap && !rsvd_pulse, "R10", "outputs idle",
              {29'd0, allow, trap, rsvd_pulse}, 32'h0);
    endtask

    task automatic t_bit_scheme;
        write_reg(1'b1, 32'hFFFF_0400);
        read_expect(1'b1, 32'h0000_0400, "R12");
        cfg_bit_scheme = 1'b1;
        probe(4'd10, 1'b0, 32'h0, 1, 0, 0, "R9");
        probe(4'd11, 1'b1, 32'h0, 0, 1, 0, "R9");
        probe(4'd0, 1'b1, 32'h0, 0, 1, 0, "R9");
        cfg_bit_scheme = 1'b0;
        probe(4'd10, 1'b1, 32'h0, 0, 1, 1, "R9");
    endtask

    task automatic t_timing;
        // permission register currently 0x00200000; cp11 field 00
        @(negedge clk);
        reg_sel = 1'b0; reg_wr_data = 32'h00C0_0000; reg_wr_en = 1'b1;
        probe(4'd11, 1'b0, 32'h0, 0, 1, 0, "R11");
        @(negedge clk);
        reg_wr_en = 1'b0;
        probe(4'd11, 1'b0, 32'h0, 1, 0, 0, "R11");
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_high_cp();
        t_mask();
        t_fields();
        t_gate();
        t_bit_scheme();
        t_timing();
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule